// File: doc/BRIEF.md
# Circular Audio Sample Writer with Half and Full Buffer Flags

This block takes a stream of audio words from a serial-audio receiver and stores them in on-chip memory without processor help. Words arrive over a valid/ready handshake. Interleaved left and right words are one stream, and they are stored in the order they arrive. The block writes each word through a one-cycle memory write port. That port carries an address, data and a write strobe.

Software gives a base address and a buffer length in words. It then raises an enable bit. The block fills the buffer from the base address, wraps back to the base after the last word, and keeps going until enable drops. Two sticky flags tell software when each half of the buffer is full. While software works on one half in place, the block fills the other half, so the single buffer acts as a ping-pong pair. Software clears each flag by writing a one to it. If a flag would be set again before software has cleared it, a sticky overrun flag is raised. A buffer length that is zero or odd is refused: the block stays idle and raises an error flag.

Top module: `audio_ring_writer`

## Requirements
- R1: Each accepted word (s_valid and s_ready high at a clock edge) appears on the memory port in the next cycle. In that cycle mem_we is 1, mem_wdata holds the word, and mem_addr is the base plus the word's position in the buffer. Words take consecutive positions in arrival order. Without an accepted word, mem_we stays 0.
- R2: After the word at position length-1 is written, the next word goes to the base address again. Filling never stops on its own. Addresses are computed modulo 2^ADDR_W.
- R3: irq_half becomes 1 in the same cycle as the memory write of position length/2-1. It stays 1 until it is cleared.
- R4: irq_full becomes 1 in the same cycle as the memory write of position length-1. It stays 1 until it is cleared.
- R5: A 1 on clr_half or clr_full at a clock edge clears the matching flag. If a new event for that flag happens at the same edge, the flag stays set.
- R6: overrun becomes 1 when a half or full event happens while its flag is still set and is not being cleared at that edge. overrun stays 1 until clr_overrun is 1 at a clock edge, unless a new overrun happens at that same edge.
- R7: At each rising edge of cfg_enable, cfg_base and cfg_len are sampled. If the length is zero or odd, len_err becomes 1, s_ready stays 0 and no memory write happens. A later start with a valid even length clears len_err.
- R8: s_ready is 0 in any cycle where cfg_enable is 0. A word accepted before enable fell is still written. After that, no more writes happen.
- R9: Each new rising edge of cfg_enable restarts filling at position 0 of the newly sampled base. Changes to cfg_base and cfg_len while filling is running have no effect.
- R10: During reset and right after it, s_ready, mem_we, irq_half, irq_full, overrun and len_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Run control; a rising edge starts filling |
| cfg_base | input | ADDR_W | Buffer base word address |
| cfg_len | input | LEN_W | Buffer length in words, must be even and non-zero |
| clr_half | input | 1 | Write-one-to-clear for irq_half |
| clr_full | input | 1 | Write-one-to-clear for irq_full |
| clr_overrun | input | 1 | Write-one-to-clear for overrun |
| s_valid | input | 1 | Incoming word valid |
| s_data | input | DATA_W | Incoming audio word |
| s_ready | output | 1 | Block accepts a word |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write word address |
| mem_wdata | output | DATA_W | Memory write data |
| irq_half | output | 1 | Sticky flag: first half filled |
| irq_full | output | 1 | Sticky flag: second half filled |
| overrun | output | 1 | Sticky flag: a flag event happened before the earlier one was cleared |
| len_err | output | 1 | Last start used a zero or odd length |

## Verification
The bench uses DATA_W=16, ADDR_W=12 and LEN_W=8. With a 12-bit address, a base a few words below 4095 makes the address roll over the top of the address space within a short run. With an 8-bit length field, the random lengths stay small. That means many half and full events and many wraps within a few thousand cycles. It also lets the bench reach the shortest legal buffer of two words, where both flag events come from adjacent words, and odd lengths close to legal ones.

// File: rtl/audio_ring_writer.sv
module audio_ring_writer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              clr_half,
  input  logic              clr_full,
  input  logic              clr_overrun,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              irq_half,
  output logic              irq_full,
  output logic              overrun,
  output logic              len_err
);

  logic              en_q;
  logic              running;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  idx;

  wire start    = cfg_enable & ~en_q;
  wire len_ok   = (cfg_len != '0) & ~cfg_len[0];
  assign s_ready = running & cfg_enable;
  wire take     = s_valid & s_ready;

  wire [LEN_W-1:0] half_last = {1'b0, len_q[LEN_W-1:1]} - 1'b1;
  wire [LEN_W-1:0] full_last = len_q - 1'b1;
  wire hit_half = take & (idx == half_last);
  wire hit_full = take & (idx == full_last);

  wire ovr_half = hit_half & irq_half & ~clr_half;
  wire ovr_full = hit_full & irq_full & ~clr_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      running <= 1'b0;
      base_q  <= '0;
      len_q   <= '0;
      idx     <= '0;
      len_err <= 1'b0;
    end else begin
      en_q <= cfg_enable;
      if (start) begin
        running <= len_ok;
        len_err <= ~len_ok;
        base_q  <= cfg_base;
        len_q   <= cfg_len;
        idx     <= '0;
      end else if (!cfg_enable) begin
        running <= 1'b0;
      end else if (take) begin
        idx <= hit_full ? '0 : idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= take;
      if (take) begin
        mem_addr  <= base_q + ADDR_W'(idx);
        mem_wdata <= s_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_half <= 1'b0;
      irq_full <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      irq_half <= hit_half | (irq_half & ~clr_half);
      irq_full <= hit_full | (irq_full & ~clr_full);
      overrun  <= ovr_half | ovr_full | (overrun & ~clr_overrun);
    end
  end

endmodule

// File: rtl/audio_ring_writer_chk.sv
module audio_ring_writer_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_enable,
  input logic              clr_half,
  input logic              s_valid,
  input logic [DATA_W-1:0] s_data,
  input logic              s_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              irq_half,
  input logic              irq_full,
  input logic              len_err
);

  a_r8_ready_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> cfg_enable);

  a_r1_write_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> mem_we);

  a_r1_data_carried: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> (mem_wdata == $past(s_data)));

  a_r1_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!(s_valid && s_ready)) |=> !mem_we);

  a_r3_half_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_half) |-> mem_we);

  a_r4_full_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_full) |-> mem_we);

  a_r5_half_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_half && !clr_half) |=> irq_half);

  a_r7_err_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> !s_ready);

endmodule

bind audio_ring_writer audio_ring_writer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .clr_half(clr_half),
  .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq_half(irq_half),
  .irq_full(irq_full), .len_err(len_err)
);

// File: tb/audio_ring_writer_bench.sv
`timescale 1ns/1ps
module audio_ring_writer_bench;
  localparam int DW = 16, AW = 12, LW = 8;

  logic clk = 0, rst_n = 0;
  logic cfg_enable = 0, clr_half = 0, clr_full = 0, clr_overrun = 0, s_valid = 0;
  logic [AW-1:0] cfg_base = '0;
  logic [LW-1:0] cfg_len = '0;
  logic [DW-1:0] s_data = '0;
  logic s_ready, mem_we, irq_half, irq_full, overrun, len_err;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  always #4 clk = ~clk;

  audio_ring_writer #(.DATA_W(DW), .ADDR_W(AW), .LEN_W(LW)) u_audio_ring_writer (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_base(cfg_base),
    .cfg_len(cfg_len), .clr_half(clr_half), .clr_full(clr_full),
    .clr_overrun(clr_overrun), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .irq_half(irq_half), .irq_full(irq_full),
    .overrun(overrun), .len_err(len_err));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  bit m_enq, m_run, m_half, m_full, m_ovr, m_err, m_we;
  int m_idx, m_len;
  logic [AW-1:0] m_base, m_addr;
  logic [DW-1:0] m_data;

  function automatic bit len_good(int l);
    return (l != 0) && (l % 2 == 0);
  endfunction

  function automatic logic [AW-1:0] addr_of(logic [AW-1:0] b, int i);
    return AW'(int'(b) + i);
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit v, bit en, bit ch, bit cf, bit co);
    bit acc, he, fe;
    s_valid = v; s_data = DW'($urandom); cfg_enable = en;
    clr_half = ch; clr_full = cf; clr_overrun = co;
    #1;
    chk(s_ready == (m_run && en), "R8 ready", s_ready, m_run && en);
    acc = v && m_run && en;
    he = 0; fe = 0;
    m_we = acc;
    if (acc) begin
      m_addr = addr_of(m_base, m_idx);
      m_data = s_data;
      he = (m_idx == m_len/2 - 1);
      fe = (m_idx == m_len - 1);
    end
    if (en && !m_enq) begin
      m_run = len_good(int'(cfg_len)); m_err = !m_run;
      m_base = cfg_base; m_len = int'(cfg_len); m_idx = 0;
    end else if (!en) m_run = 0;
    else if (acc) m_idx = fe ? 0 : m_idx + 1;
    m_enq = en;
    m_ovr = (he && m_half && !ch) || (fe && m_full && !cf) || (m_ovr && !co);
    m_half = he || (m_half && !ch);
    m_full = fe || (m_full && !cf);
    @(negedge clk);
    chk(mem_we == m_we, "R1 mem_we", mem_we, m_we);
    if (m_we) begin
      chk(mem_addr == m_addr, "R2 mem_addr", mem_addr, m_addr);
      chk(mem_wdata == m_data, "R1 mem_wdata", mem_wdata, m_data);
    end
    chk(irq_half == m_half, "R3 irq_half", irq_half, m_half);
    chk(irq_full == m_full, "R4 irq_full", irq_full, m_full);
    chk(overrun == m_ovr, "R6 overrun", overrun, m_ovr);
    chk(len_err == m_err, "R7 len_err", len_err, m_err);
  endtask

  task automatic restart(logic [AW-1:0] b, int l);
    step(0, 0, 1, 1, 1);
    cfg_base = b; cfg_len = LW'(l);
    step(0, 1, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_a0d1));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!s_ready && !mem_we && !irq_half && !irq_full && !overrun && !len_err,
        "R10 reset", {s_ready, mem_we, irq_half, irq_full, overrun, len_err}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!s_ready && !mem_we && !irq_half && !len_err, "R10 after reset",
        {s_ready, mem_we, irq_half, len_err}, 0);

    // R1 R2 R3 R4: continuous stream, length 8, two wraps
    restart(12'h100, 8);
    for (int i = 0; i < 20; i++) step(1, 1, irq_half, irq_full, 0);
    // R6: no clearing, overrun builds up; R5 set-wins
    for (int i = 0; i < 16; i++) step(1, 1, 0, 0, 0);
    for (int i = 0; i < 8; i++) step(1, 1, 1, 1, 1);
    // R2: wrap across top of address space
    restart(12'hFFC, 6);
    for (int i = 0; i < 14; i++) step(1, 1, 1, 1, 1);
    // R9: config changes while running are ignored
    cfg_base = 12'h055; cfg_len = 8'd3;
    for (int i = 0; i < 8; i++) step(1, 1, 0, 0, 1);
    // R7: odd and zero lengths
    restart(12'h200, 5);
    for (int i = 0; i < 6; i++) step(1, 1, 0, 0, 1);
    restart(12'h200, 0);
    for (int i = 0; i < 4; i++) step(1, 1, 0, 0, 1);
    // smallest legal buffer
    restart(12'h300, 2);
    for (int i = 0; i < 6; i++) step(1, 1, 0, 0, 0);
    // R8: disable mid-stream then restart R9
    for (int i = 0; i < 3; i++) step(1, 0, 1, 1, 1);
    restart(12'h340, 4);
    for (int i = 0; i < 5; i++) step(1, 1, 1, 1, 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit en;
      en = ($urandom % 60) != 0 ? cfg_enable : !cfg_enable;
      if (!cfg_enable && en) begin
        cfg_base = AW'($urandom);
        cfg_len = ($urandom % 8 == 0) ? LW'($urandom % 16) : LW'(2 * (1 + $urandom % 10));
      end
      if ($urandom % 50 == 0) cfg_len = LW'($urandom);
      step(($urandom % 4) != 0, en, ($urandom % 3) == 0, ($urandom % 3) == 0,
           ($urandom % 8) == 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule